// File: doc/BRIEF.md
# Triangle-Wave Frequency Dither Generator

This block produces a signed offset word that sweeps up and down in a symmetric triangle. A clock generator adds the word to its centre setting, which spreads the output frequency and lowers the peaks of its radiated emission spectrum. One two-bit code sets how long a triangle period lasts, as a power-of-two count of master clock cycles. A second two-bit code sets the peak deviation as ±1, ±2, ±4 or ±8 percent of the centre frequency. The word uses a scale on which ±8 percent equals ±127.

The generator runs only while the spread-enable input is high. A five-state machine steps through the waveform one quarter at a time. ST_IDLE moves to ST_RISE_POS when enable is seen high. ST_RISE_POS moves to ST_FALL_POS at the end of a quarter. ST_FALL_POS then moves to ST_FALL_NEG, and ST_FALL_NEG moves to ST_RISE_NEG. ST_RISE_NEG wraps back to ST_RISE_POS, which starts a new period and takes in the codes. From every state, a low enable goes straight to ST_IDLE.

A period strobe marks the first cycle of each period. A new rate or amplitude code takes effect only at a period start, so the waveform never jumps.

Top module: `dither_tri_gen`

## Requirements
- R1: While running, at phase p of a period of N cycles with quarter length Q = N/4, the offset magnitude is floor(m*127/Q) shifted right by the amplitude shift. Here m = p in the first quarter, 2Q-p in the second, p-2Q in the third and 4Q-p in the fourth. The sign is positive in the first two quarters and negative in the last two.
- R2: Rate code 00 gives a period of 2048 master cycles, code 01 gives 4096, and codes 10 and 11 both give 8192.
- R3: The amplitude code sets the peak offset. Code 11 (±8%) gives ±127, 10 (±4%) gives ±63, 01 (±2%) gives ±31 and 00 (±1%) gives ±15.
- R4: The negative half of a period mirrors the positive half. The lowest value in a period is the negative of the highest, and the sum of the offsets over one full period is zero.
- R5: While spread-enable is low, the offset is zero and the strobe is low. When enable is seen low at a clock edge, the offset is zero from that edge on and the phase resets.
- R6: When enable is seen high at a clock edge while idle, a period starts at that edge: the strobe is high and the offset is zero in the following cycle.
- R7: The period strobe is high exactly in the cycle at phase 0 of each period, and only while running.
- R8: A rate or amplitude code is captured only at a period start. A change part way through a period does not alter the waveform before the next period begins.
- R9: During and right after reset, the block is idle with offset zero and strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| spread_en_i | input | 1 | Dither enable |
| rate_sel_i | input | 2 | Period code: 00 /2048, 01 /4096, 10 and 11 /8192 |
| amp_sel_i | input | AMP_W (2) | Peak code: 00 ±1%, 01 ±2%, 10 ±4%, 11 ±8% |
| offset_o | output | OFFSET_W (8) | Two's-complement offset word |
| period_o | output | 1 | High in the first cycle of each period |

## Verification
All results come from registered state through combinational shaping, so they are due in the cycle after the clock edge that samples the input. That edge starts a period (strobe and zero offset), forces the offset to zero, or captures a new code. The bench drives inputs on the falling edge. Its reference model advances on the rising edge, and the bench compares both outputs with the model on every falling edge. Period length, peak, mirror and zero sum are checked when each period that ran in full comes to an end.

// File: rtl/dither_tri_pkg.sv
package dither_tri_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RISE_POS = 3'd1,
        ST_FALL_POS = 3'd2,
        ST_FALL_NEG = 3'd3,
        ST_RISE_NEG = 3'd4
    } dith_state_e;

    localparam int RATE_W     = 2;
    localparam int RATE_CODES = 4;
    localparam int RATE_STEPS = 2;

    function automatic int unsigned rate_steps(input logic [RATE_W-1:0] code);
        return (int'(code) > RATE_STEPS) ? RATE_STEPS : int'(code);
    endfunction

endpackage

// File: rtl/dither_seq.sv
module dither_seq
    import dither_tri_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int AMP_W     = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 en_i,
    input  logic [RATE_W-1:0]    rate_i,
    input  logic [AMP_W-1:0]     amp_i,
    output dith_state_e          st_o,
    output logic [BASE_LOG2-1:0] lo_o,
    output logic [RATE_W-1:0]    rate_q_o,
    output logic [AMP_W-1:0]     amp_q_o
);

    localparam int QMIN_LOG2 = BASE_LOG2 - 2;
    localparam int LO_W      = BASE_LOG2;

    dith_state_e      st_q, st_d;
    logic [LO_W-1:0]  lo_q, lo_d;
    logic [RATE_W-1:0] rate_q;
    logic [AMP_W-1:0]  amp_q;
    logic              take_cfg;
    logic [LO_W-1:0]   qlast_tbl [RATE_CODES];
    logic [LO_W-1:0]   qlast;
    logic              q_end;

    for (genvar g = 0; g < RATE_CODES; g++) begin : g_qlast
        localparam int SH = QMIN_LOG2 + ((g > RATE_STEPS) ? RATE_STEPS : g);
        assign qlast_tbl[g] = LO_W'((64'd1 << SH) - 64'd1);
    end

    assign qlast = qlast_tbl[rate_q];
    assign q_end = (lo_q == qlast);

    always_comb begin
        st_d     = st_q;
        lo_d     = lo_q + LO_W'(1);
        take_cfg = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                lo_d = '0;
                if (en_i) begin
                    st_d     = ST_RISE_POS;
                    take_cfg = 1'b1;
                end
            end
            ST_RISE_POS: if (q_end) begin st_d = ST_FALL_POS; lo_d = '0; end
            ST_FALL_POS: if (q_end) begin st_d = ST_FALL_NEG; lo_d = '0; end
            ST_FALL_NEG: if (q_end) begin st_d = ST_RISE_NEG; lo_d = '0; end
            ST_RISE_NEG: begin
                if (q_end) begin
                    st_d     = ST_RISE_POS;
                    lo_d     = '0;
                    take_cfg = 1'b1;
                end
            end
            default: begin
                st_d = ST_IDLE;
                lo_d = '0;
            end
        endcase
        if (!en_i) begin
            st_d     = ST_IDLE;
            lo_d     = '0;
            take_cfg = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q   <= ST_IDLE;
            lo_q   <= '0;
            rate_q <= '0;
            amp_q  <= '0;
        end else begin
            st_q <= st_d;
            lo_q <= lo_d;
            if (take_cfg) begin
                rate_q <= rate_i;
                amp_q  <= amp_i;
            end
        end
    end

    assign st_o     = st_q;
    assign lo_o     = lo_q;
    assign rate_q_o = rate_q;
    assign amp_q_o  = amp_q;

endmodule

// File: rtl/dither_shaper.sv
module dither_shaper
    import dither_tri_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int AMP_W     = 2,
    parameter int OFFSET_W  = 8
) (
    input  dith_state_e          st_i,
    input  logic [BASE_LOG2-1:0] lo_i,
    input  logic [RATE_W-1:0]    rate_q_i,
    input  logic [AMP_W-1:0]     amp_q_i,
    output logic [OFFSET_W-1:0]  offset_o,
    output logic                 period_o
);

    localparam int QMIN_LOG2 = BASE_LOG2 - 2;
    localparam int M_W       = BASE_LOG2 + 1;
    localparam int MAG_W     = OFFSET_W - 1;
    localparam int PEAK      = (1 << MAG_W) - 1;
    localparam int PROD_W    = M_W + MAG_W;
    localparam int AMP_MAX   = (1 << AMP_W) - 1;

    int unsigned        qlog;
    logic [M_W-1:0]     quarter;
    logic [M_W-1:0]     m_val;
    logic [PROD_W-1:0]  prod;
    logic [PROD_W-1:0]  scaled;
    logic [MAG_W-1:0]   mag;
    logic [AMP_W-1:0]   sh;
    logic [MAG_W-1:0]   mag_sh;
    logic [OFFSET_W-1:0] word;
    logic               mirrored;
    logic               negative;

    always_comb begin
        qlog     = QMIN_LOG2 + rate_steps(rate_q_i);
        quarter  = M_W'(1) << qlog;
        mirrored = (st_i == ST_FALL_POS) || (st_i == ST_RISE_NEG);
        negative = (st_i == ST_FALL_NEG) || (st_i == ST_RISE_NEG);
        m_val    = mirrored ? (quarter - {1'b0, lo_i}) : {1'b0, lo_i};
        prod     = PROD_W'(m_val) * PROD_W'(PEAK);
        scaled   = prod >> qlog;
        mag      = scaled[MAG_W-1:0];
        sh       = AMP_W'(AMP_MAX) - amp_q_i;
        mag_sh   = mag >> sh;
        word     = {1'b0, mag_sh};
        if (st_i == ST_IDLE) begin
            offset_o = '0;
        end else if (negative) begin
            offset_o = (~word) + OFFSET_W'(1);
        end else begin
            offset_o = word;
        end
        period_o = (st_i == ST_RISE_POS) && (lo_i == '0);
    end

endmodule

// File: rtl/dither_tri_gen.sv
module dither_tri_gen
    import dither_tri_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int AMP_W     = 2,
    parameter int OFFSET_W  = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                spread_en_i,
    input  logic [1:0]          rate_sel_i,
    input  logic [AMP_W-1:0]    amp_sel_i,
    output logic [OFFSET_W-1:0] offset_o,
    output logic                period_o
);

    dith_state_e          st;
    logic [BASE_LOG2-1:0] lo;
    logic [RATE_W-1:0]    rate_q;
    logic [AMP_W-1:0]     amp_q;

    dither_seq #(
        .BASE_LOG2 (BASE_LOG2),
        .AMP_W     (AMP_W)
    ) u_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (spread_en_i),
        .rate_i   (rate_sel_i),
        .amp_i    (amp_sel_i),
        .st_o     (st),
        .lo_o     (lo),
        .rate_q_o (rate_q),
        .amp_q_o  (amp_q)
    );

    dither_shaper #(
        .BASE_LOG2 (BASE_LOG2),
        .AMP_W     (AMP_W),
        .OFFSET_W  (OFFSET_W)
    ) u_shape (
        .st_i     (st),
        .lo_i     (lo),
        .rate_q_i (rate_q),
        .amp_q_i  (amp_q),
        .offset_o (offset_o),
        .period_o (period_o)
    );

endmodule

// File: rtl/dither_tri_gen_chk.sv
module dither_tri_gen_chk
    import dither_tri_pkg::*;
#(
    parameter int AMP_W    = 2,
    parameter int OFFSET_W = 8
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                spread_en_i,
    input logic [OFFSET_W-1:0] offset_o,
    input logic                period_o,
    input dith_state_e         st_i,
    input logic [RATE_W-1:0]   rate_q_i,
    input logic [AMP_W-1:0]    amp_q_i
);

    logic [OFFSET_W-1:0]      prev_off;
    logic signed [OFFSET_W:0] diff;

    always_ff @(posedge clk_i) begin
        prev_off <= offset_o;
    end

    assign diff = $signed({offset_o[OFFSET_W-1], offset_o}) -
                  $signed({prev_off[OFFSET_W-1], prev_off});

    // R5: a low enable leaves the block idle in the next cycle
    p_idle_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !spread_en_i |=> (offset_o == '0 && !period_o));

    // R6: enable seen while idle starts a period at once
    p_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_i == ST_IDLE && spread_en_i) |=> (period_o && offset_o == '0));

    // R1: the triangle never moves by more than one step per cycle
    p_slew_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_i != ST_IDLE && spread_en_i) |=> (diff >= -1 && diff <= 1));

    // R4: the most negative code is never produced
    p_sym_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        offset_o != {1'b1, {(OFFSET_W-1){1'b0}}});

    // R7: the strobe only appears while running, at the zero crossing
    p_strobe_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        period_o |-> (offset_o == '0 && st_i == ST_RISE_POS));

    // R8: captured codes change only where a period begins
    p_cfg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !period_o |-> ($stable(rate_q_i) && $stable(amp_q_i)));

endmodule

bind dither_tri_gen dither_tri_gen_chk #(
    .AMP_W    (AMP_W),
    .OFFSET_W (OFFSET_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .spread_en_i (spread_en_i),
    .offset_o    (offset_o),
    .period_o    (period_o),
    .st_i        (st),
    .rate_q_i    (rate_q),
    .amp_q_i     (amp_q)
);

// File: tb/dither_tri_gen_tb.sv
`timescale 1ns/1ps
module dither_tri_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] rate = 2'b00;
    logic [1:0] amp = 2'b11;
    logic [7:0] offset;
    logic       strobe;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string ctx = "R9";

    always #4 clk = ~clk;

    dither_tri_gen dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .spread_en_i (en),
        .rate_sel_i  (rate),
        .amp_sel_i   (amp),
        .offset_o    (offset),
        .period_o    (strobe)
    );

    // behavioural reference
    int m_run = 0, m_p = 0, m_rate = 0, m_amp = 0;

    function automatic int div_of(input int code);
        if (code == 0) return 2048;
        if (code == 1) return 4096;
        return 8192;
    endfunction

    function automatic int expect_off();
        int n, q, quad, lo, m, mag;
        if (m_run == 0) return 0;
        n = div_of(m_rate);
        q = n / 4;
        quad = m_p / q;
        lo = m_p % q;
        m = (quad == 1 || quad == 3) ? q - lo : lo;
        mag = (m * 127) / q;
        mag = mag >> (3 - m_amp);
        return (quad >= 2) ? -mag : mag;
    endfunction

    always @(posedge clk) begin
        if (!rst_n || !en) begin
            m_run = 0;
            m_p = 0;
        end else if (m_run == 0) begin
            m_run = 1;
            m_p = 0;
            m_rate = int'(rate);
            m_amp = int'(amp);
        end else begin
            m_p = m_p + 1;
            if (m_p == div_of(m_rate)) begin
                m_p = 0;
                m_rate = int'(rate);
                m_amp = int'(amp);
            end
        end
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // per-cycle comparison and per-period statistics
    int got, exp_v;
    int full = 0, acc = 0, pmax = 0, pmin = 0, p_start = 0, p_n = 0, p_peak = 0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        got = int'($signed(offset));
        exp_v = expect_off();
        checks = checks + 1;
        if (got != exp_v) begin
            errors = errors + 1;
            $display("FAIL %s offset at cycle %0d: got %0d expected %0d",
                     (m_run == 0 && ctx != "R9") ? "R5" : ctx, cyc, got, exp_v);
        end
        checks = checks + 1;
        if (strobe !== (m_run != 0 && m_p == 0)) begin
            errors = errors + 1;
            $display("FAIL R7 strobe at cycle %0d: got %0b expected %0b",
                     cyc, strobe, (m_run != 0 && m_p == 0));
        end
        if (m_run != 0) begin
            if (m_p == 0) begin
                if (full != 0) begin
                    checks = checks + 4;
                    if (cyc - p_start != p_n) begin
                        errors = errors + 1;
                        $display("FAIL R2 period length: got %0d expected %0d", cyc - p_start, p_n);
                    end
                    if (pmax != p_peak) begin
                        errors = errors + 1;
                        $display("FAIL R3 peak: got %0d expected %0d", pmax, p_peak);
                    end
                    if (pmin != -pmax) begin
                        errors = errors + 1;
                        $display("FAIL R4 trough: got %0d expected %0d", pmin, -pmax);
                    end
                    if (acc != 0) begin
                        errors = errors + 1;
                        $display("FAIL R4 period sum: got %0d expected 0", acc);
                    end
                end
                full = 1;
                acc = 0;
                pmax = got;
                pmin = got;
                p_start = cyc;
                p_n = div_of(m_rate);
                p_peak = 127 >> (3 - m_amp);
            end
            acc = acc + got;
            if (got > pmax) pmax = got;
            if (got < pmin) pmin = got;
        end else begin
            full = 0;
        end
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL R2 watchdog expired: got %0d cycles expected at most 150000", cyc);
            summary();
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_period_start();
        @(negedge clk);
        while (!(m_run != 0 && m_p == 0)) @(negedge clk);
    endtask

    initial begin
        ctx = "R9";
        run(5);
        rst_n = 1'b1;
        run(3);
        ctx = "R5";
        run(10);
        // R6: start with /2048 at full amplitude
        ctx = "R6";
        en = 1'b1;
        run(2);
        ctx = "R1";
        run(1000);
        // R8: amplitude and rate changed mid-period
        ctx = "R8";
        amp = 2'b10;
        rate = 2'b01;
        wait_period_start();
        ctx = "R1";
        run(4096 * 2 + 5);
        // R2: slowest codes, R3: smaller amplitudes
        rate = 2'b10;
        amp = 2'b01;
        wait_period_start();
        run(8192 + 5);
        rate = 2'b11;
        amp = 2'b00;
        wait_period_start();
        run(8192 * 2 + 5);
        rate = 2'b00;
        amp = 2'b11;
        wait_period_start();
        run(2048 * 2 + 300);
        // R5: drop enable mid-period, then restart
        ctx = "R5";
        en = 1'b0;
        run(40);
        ctx = "R6";
        en = 1'b1;
        run(2);
        ctx = "R1";
        run(2048 * 2 + 10);
        summary();
    end

endmodule